// File: doc/BRIEF.md
# Selectable Self-Synchronizing Randomizer / Derandomizer

This block scrambles or descrambles a serial telemetry bit stream, one bit per valid cycle. It applies multiplicative (self-synchronizing) scrambling with one of seven trinomial polynomials. Five of them are of the RNRZ family, with register lengths 9, 11, 15, 17 and 23. Two are twenty-stage modem-style polynomials. Each RNRZ length can run with forward or mirrored tap placement. The same datapath does both jobs. In randomize mode, the shift register is fed with the block's own output. In derandomize mode, it is fed with the received bit. The derandomizer therefore realigns itself, with no framing signal, once a register's worth of bits has been received.

A small controller is built around three named states. PASS means the block is disabled or the code is reserved, and bits go through unchanged. FILL means the register has been cleared and fewer valid bits than the register length have been shifted in. SYNC means the register is fully populated from live data. The transitions are as follows. From any state, a change of configuration moves the block to FILL if the new configuration is active and to PASS if it is not. FILL moves to SYNC on the valid bit that brings the count up to the register length. SYNC and PASS hold until the configuration changes again. The settled output tells downstream logic when the derandomized bits can be trusted.

Top module: `tlm_scrambler`

## Requirements
- R1: After reset, o_valid and o_bit are 0, the register is clear and the state is PASS, with the configuration taken as all zero (disabled, code 0, forward, randomize).
- R2: o_valid equals i_valid delayed by exactly one clock, and o_bit and o_settled belong to the bit presented on that earlier cycle.
- R3: i_mode selects the polynomial x^N + x^K + 1 as follows: 0 gives N=9,K=5; 1 gives N=11,K=9; 2 gives N=15,K=14; 3 gives N=17,K=14; 4 gives N=23,K=18; 5 gives N=20,K=3; 6 gives N=20,K=17. The output is y(t) = d(t) xor s(t-K) xor s(t-N), where any s from before the last clear is 0.
- R4: With i_rev=1, codes 0 to 4 use K' = N-K (taps 4, 2, 1, 3 and 5). Codes 5 and 6 ignore i_rev.
- R5: With i_dir=0 (randomize), s is the block's own output sequence. With i_dir=1 (derandomize), s is the input sequence, so derandomizing a randomized stream returns the original bits.
- R6: In derandomize mode, an output bit is correct whenever the N preceding inputs are correct. A single flipped input bit therefore corrupts exactly three output bits.
- R7: When i_en=0 or i_mode=7, o_bit equals the input bit, o_settled is 1 and the register does not shift.
- R8: Any change of i_en, i_mode, i_rev or i_dir clears the register and the fill count. A valid bit in that same cycle is processed with the new setting, starting from an empty register.
- R9: For an active setting, o_settled is 0 for the first N valid bits after a clear and 1 from bit N (counting from 0) onward.
- R10: Cycles with i_valid=0 change neither the register nor the fill count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_en | input | 1 | Enable; 0 passes data through |
| i_mode | input | 3 | Polynomial code 0 to 6; 7 is pass-through |
| i_rev | input | 1 | Mirrored tap placement for codes 0 to 4 |
| i_dir | input | 1 | 0 randomize, 1 derandomize |
| i_valid | input | 1 | Input bit qualifier |
| i_bit | input | 1 | Serial input bit |
| o_valid | output | 1 | Output bit qualifier, one cycle after i_valid |
| o_bit | output | 1 | Scrambled or descrambled bit |
| o_settled | output | 1 | Register fully populated since the last clear |

## Verification
A configuration change and a valid data bit can land on the same clock. In that cycle the block has to clear its register, restart the fill count and still process the bit from an empty register with the new polynomial. The bench provokes this by switching mode, tap orientation or direction while i_valid is held high. It judges every output bit, and the settled flag, against a queue-based behavioural model that clears its history on exactly that cycle. A second overlap is the fill count reaching N on the same bit that a valid gap precedes. Interleaved idle cycles check that the count and the register hold still across such gaps.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int SR_W  = 23;
    localparam int LEN_W = 5;

    typedef enum logic [2:0] {
        POLY_R9  = 3'd0,
        POLY_R11 = 3'd1,
        POLY_R15 = 3'd2,
        POLY_R17 = 3'd3,
        POLY_R23 = 3'd4,
        POLY_VA  = 3'd5,
        POLY_VB  = 3'd6,
        POLY_OFF = 3'd7
    } poly_e;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_FILL = 2'd1,
        ST_SYNC = 2'd2
    } st_e;

    typedef struct packed {
        logic  en;
        logic  rev;
        logic  dir;
        poly_e poly;
    } cfg_t;
endpackage

// File: rtl/scr_taps.sv
module scr_taps
    import scr_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  poly_e             poly,
    input  logic              rev,
    output logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  tap
);
    logic [LEN_W-1:0] fwd_tap;
    logic             mirror_ok;

    always_comb begin
        mirror_ok = 1'b1;
        unique case (poly)
            POLY_R9:  begin len = LEN_W'(9);  fwd_tap = LEN_W'(5);  end
            POLY_R11: begin len = LEN_W'(11); fwd_tap = LEN_W'(9);  end
            POLY_R15: begin len = LEN_W'(15); fwd_tap = LEN_W'(14); end
            POLY_R17: begin len = LEN_W'(17); fwd_tap = LEN_W'(14); end
            POLY_R23: begin len = LEN_W'(23); fwd_tap = LEN_W'(18); end
            POLY_VA:  begin len = LEN_W'(20); fwd_tap = LEN_W'(3);  mirror_ok = 1'b0; end
            POLY_VB:  begin len = LEN_W'(20); fwd_tap = LEN_W'(17); mirror_ok = 1'b0; end
            default:  begin len = LEN_W'(20); fwd_tap = LEN_W'(3);  mirror_ok = 1'b0; end
        endcase
        tap = (rev && mirror_ok) ? (len - fwd_tap) : fwd_tap;
    end
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
    import scr_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              i_cfg,
    input  logic              i_valid,
    input  logic [LEN_W-1:0]  len,
    output logic              clr,
    output logic              active,
    output logic              settled_now
);
    cfg_t             cfg_q;
    st_e              state_q, state_n, base_st;
    logic [LEN_W-1:0] cnt_q, cnt_n, base_cnt;

    always_comb begin
        clr      = (i_cfg != cfg_q);
        active   = i_cfg.en && (i_cfg.poly != POLY_OFF);
        base_st  = clr ? (active ? ST_FILL : ST_PASS) : state_q;
        base_cnt = clr ? '0 : cnt_q;
    end

    // next-state process
    always_comb begin
        state_n = base_st;
        cnt_n   = base_cnt;
        unique case (base_st)
            ST_PASS: cnt_n = '0;
            ST_FILL: begin
                if (i_valid) begin
                    cnt_n = base_cnt + 1'b1;
                    if (base_cnt + 1'b1 == len) state_n = ST_SYNC;
                end
            end
            ST_SYNC: cnt_n = base_cnt;
            default: state_n = ST_PASS;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            cfg_q   <= i_cfg;
        end
    end

    // output process
    always_comb begin
        unique case (base_st)
            ST_PASS: settled_now = 1'b1;
            ST_FILL: settled_now = 1'b0;
            ST_SYNC: settled_now = 1'b1;
            default: settled_now = 1'b1;
        endcase
    end

    a_r9_sync_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && !clr) |-> (cnt_q == len));
    a_r7_pass_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && !clr) |-> !active);
    a_r10_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_valid && !clr) |=> $stable(cnt_q));
    a_r8_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !i_valid) |=> (cnt_q == '0));
endmodule

// File: rtl/scr_core.sv
module scr_core #(
    parameter int SR_W  = 23,
    parameter int LEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              active,
    input  logic              shift,
    input  logic              dir,
    input  logic              d,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  tap,
    output logic              y
);
    logic [SR_W-1:0] sr_q, s_eff;
    logic            t_long, t_short, fb;

    always_comb begin
        s_eff   = clr ? '0 : sr_q;
        t_long  = s_eff[len - 1'b1];
        t_short = s_eff[tap - 1'b1];
        y       = active ? (d ^ t_long ^ t_short) : d;
        fb      = dir ? d : y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sr_q <= '0;
        else if (shift)  sr_q <= {s_eff[SR_W-2:0], fb};
        else if (clr)    sr_q <= '0;
    end

    a_r8_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !shift) |=> (sr_q == '0));
    a_r8_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && shift) |=> (sr_q[SR_W-1:1] == '0));
    a_r10_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clr) |=> $stable(sr_q));
endmodule

// File: rtl/tlm_scrambler.sv
module tlm_scrambler
    import scr_pkg::*;
#(
    parameter int SR_W  = scr_pkg::SR_W,
    parameter int LEN_W = scr_pkg::LEN_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_en,
    input  logic [2:0] i_mode,
    input  logic       i_rev,
    input  logic       i_dir,
    input  logic       i_valid,
    input  logic       i_bit,
    output logic       o_valid,
    output logic       o_bit,
    output logic       o_settled
);
    cfg_t             cfg;
    logic [LEN_W-1:0] len, tap;
    logic             clr, active, settled_now, y;

    always_comb begin
        cfg.en   = i_en;
        cfg.rev  = i_rev;
        cfg.dir  = i_dir;
        cfg.poly = poly_e'(i_mode);
    end

    scr_taps #(.LEN_W(LEN_W)) u_taps (
        .poly (cfg.poly),
        .rev  (i_rev),
        .len  (len),
        .tap  (tap)
    );

    scr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_cfg       (cfg),
        .i_valid     (i_valid),
        .len         (len),
        .clr         (clr),
        .active      (active),
        .settled_now (settled_now)
    );

    scr_core #(.SR_W(SR_W), .LEN_W(LEN_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .active (active),
        .shift  (i_valid && active),
        .dir    (i_dir),
        .d      (i_bit),
        .len    (len),
        .tap    (tap),
        .y      (y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid   <= 1'b0;
            o_bit     <= 1'b0;
            o_settled <= 1'b0;
        end else begin
            o_valid   <= i_valid;
            o_bit     <= i_valid ? y : 1'b0;
            o_settled <= settled_now;
        end
    end

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> !o_valid);
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !active) |=> (o_bit == $past(i_bit) && o_settled));
    a_r9_fill_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && active && clr) |=> !o_settled);
endmodule

// File: tb/tlm_scrambler_tb.sv
module tlm_scrambler_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, rev = 1'b0, dir = 1'b0, vld = 1'b0, din = 1'b0;
    logic [2:0] mode = 3'd0;
    logic o_valid, o_bit, o_settled;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    string cur_req = "R3";

    bit       m_h[$];
    bit       g_h[$];
    int       m_cnt = 0;
    bit [5:0] m_cfg = '0;

    always #4 clk = ~clk;

    tlm_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .i_en(en), .i_mode(mode), .i_rev(rev),
        .i_dir(dir), .i_valid(vld), .i_bit(din),
        .o_valid(o_valid), .o_bit(o_bit), .o_settled(o_settled)
    );

    task automatic poly_of(input bit [2:0] m, input bit r, output int n, output int k);
        case (m)
            3'd0: begin n = 9;  k = 5;  end
            3'd1: begin n = 11; k = 9;  end
            3'd2: begin n = 15; k = 14; end
            3'd3: begin n = 17; k = 14; end
            3'd4: begin n = 23; k = 18; end
            3'd5: begin n = 20; k = 3;  end
            default: begin n = 20; k = 17; end
        endcase
        if (r && m <= 3'd4) k = n - k;
    endtask

    task automatic check(input bit ok, input string req, input int got, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // independent randomizer used to build streams
    task automatic gen_scr(input int n, input int k, input bit d, output bit y);
        bit a, b;
        a = (g_h.size() >= k) ? g_h[k-1] : 1'b0;
        b = (g_h.size() >= n) ? g_h[n-1] : 1'b0;
        y = d ^ a ^ b;
        g_h.push_front(y);
        if (g_h.size() > 32) void'(g_h.pop_back());
    endtask

    // one clock: model prediction, drive, sample after the edge
    task automatic apply(input bit v, input bit d, output bit got);
        bit [5:0] c;
        bit act, e_bit, e_set, a, b, fb;
        int n, k;
        c = {en, rev, dir, mode};
        if (c != m_cfg) begin
            m_h.delete();
            m_cnt = 0;
            m_cfg = c;
        end
        act = en && (mode != 3'd7);
        e_bit = d;
        e_set = 1'b1;
        if (v && act) begin
            poly_of(mode, rev, n, k);
            a = (m_h.size() >= k) ? m_h[k-1] : 1'b0;
            b = (m_h.size() >= n) ? m_h[n-1] : 1'b0;
            e_bit = d ^ a ^ b;
            fb = dir ? d : e_bit;
            m_h.push_front(fb);
            if (m_h.size() > 32) void'(m_h.pop_back());
            e_set = (m_cnt >= n);
            if (m_cnt < n) m_cnt++;
        end
        vld = v;
        din = d;
        @(posedge clk);
        #1;
        got = o_bit;
        check(o_valid == v, "R2", o_valid, v);
        if (v) begin
            check(o_bit == e_bit, cur_req, o_bit, e_bit);
            check(o_settled == e_set, "R9", o_settled, e_set);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        bit g, y;
        bit orig[$];
        bit scr[$];
        int n, k, errs;
        repeat (3) @(posedge clk);
        #1;
        check(o_valid == 1'b0, "R1", o_valid, 0);
        check(o_bit == 1'b0, "R1", o_bit, 0);
        rst_n = 1'b1;

        // R3/R5: forward randomize on each code, with idle gaps (R10)
        en = 1'b1;
        for (int m = 0; m < 7; m++) begin
            mode = 3'(m);
            cur_req = "R3";
            for (int i = 0; i < 60; i++) begin
                if (i % 7 == 3) begin cur_req = "R10"; apply(1'b0, 1'b0, g); cur_req = "R3"; end
                apply(1'b1, 1'($urandom_range(0, 1)), g);
            end
        end

        // R4: mirrored taps, including codes that ignore it
        rev = 1'b1;
        cur_req = "R4";
        for (int m = 0; m < 7; m++) begin
            mode = 3'(m);
            for (int i = 0; i < 50; i++) apply(1'b1, 1'($urandom_range(0, 1)), g);
        end

        // R5: round trip on code 2 forward
        rev = 1'b0; mode = 3'd2; dir = 1'b0;
        apply(1'b0, 1'b0, g);
        poly_of(3'd2, 1'b0, n, k);
        g_h.delete();
        for (int i = 0; i < 80; i++) begin
            orig.push_back(1'($urandom_range(0, 1)));
            gen_scr(n, k, orig[i], y);
            scr.push_back(y);
        end
        dir = 1'b1;
        cur_req = "R5";
        for (int i = 0; i < 80; i++) begin
            apply(1'b1, scr[i], g);
            if (i >= n) check(g == orig[i], "R5", g, orig[i]);
        end

        // R6: single error on derandomizer input, code 4 mirrored
        mode = 3'd4; rev = 1'b1; dir = 1'b1;
        apply(1'b0, 1'b0, g);
        poly_of(3'd4, 1'b1, n, k);
        g_h.delete();
        orig.delete(); scr.delete();
        for (int i = 0; i < 100; i++) begin
            orig.push_back(1'($urandom_range(0, 1)));
            gen_scr(n, k, orig[i], y);
            scr.push_back(y);
        end
        scr[50] = ~scr[50];
        errs = 0;
        cur_req = "R6";
        for (int i = 0; i < 100; i++) begin
            apply(1'b1, scr[i], g);
            if (i >= n && g != orig[i]) errs++;
        end
        check(errs == 3, "R6", errs, 3);

        // R8/R9: configuration change on a valid cycle, settled edge
        dir = 1'b0; rev = 1'b0; mode = 3'd1;
        cur_req = "R8";
        for (int i = 0; i < 30; i++) begin
            if (i == 10) mode = 3'd3;
            if (i == 18) rev = 1'b1;
            apply(1'b1, 1'($urandom_range(0, 1)), g);
        end
        mode = 3'd1; rev = 1'b0;
        for (int i = 0; i < 13; i++) begin
            apply(1'b1, 1'b1, g);
            if (i == 10) check(o_settled == 1'b0, "R9", o_settled, 0);
            if (i == 11) check(o_settled == 1'b1, "R9", o_settled, 1);
        end

        // R7: disabled and reserved code pass bits through
        cur_req = "R7";
        en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            bit d = 1'($urandom_range(0, 1));
            apply(1'b1, d, g);
            check(g == d && o_settled, "R7", g, d);
        end
        en = 1'b1; mode = 3'd7;
        for (int i = 0; i < 12; i++) begin
            bit d = 1'($urandom_range(0, 1));
            apply(1'b1, d, g);
            check(g == d, "R7", g, d);
        end
        apply(1'b0, 1'b0, g);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule